// File: doc/BRIEF.md
# Locked Configuration Port Controller

This block guards a configuration register space behind a byte-wide I/O port pair. A host on a simple bus (address, write data, read data, write strobe, read strobe) must write a magic byte twice in a row to the port's base address before anything behind the port can be touched. After that, the base address acts as an index register and the next address up acts as a data window onto the register named by the index. A single write of an exit byte to the base address locks the port again.

The register space has a global part and a banked part. A selector register picks one of several logical devices, and banked indices then reach that device's private register set. Global registers are reached the same way whatever device is selected. One bit in a global register moves the whole port between two base addresses. A strap input gives that bit its reset value.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The port opens only after two back-to-back writes of 0x87 to the base address. Once open, a read of the base address returns the index register.
- R2: Any write to the base address that is not 0x87 while the port is closed clears unlock progress. This includes a write that falls between the two 0x87 bytes.
- R3: While open, one write of 0xAA to the base address closes the port. A later 0x87 pair opens it again. While open, any other byte written to the base address loads the index.
- R4: The index register sits at the base address and the data window at base+1. While closed, reads of either address return 0xFF.
- R5: While closed, writes to the data window change no register.
- R6: Bit 6 of global register 0x26 picks the base address. Clear gives 0x2E/0x2F and set gives 0x4E/0x4F. A write to that bit steers decoding from the next bus cycle on, and strap_i sets its reset value.
- R7: A write to index 0x07 through the data window selects logical device wdata[1:0]. Reading index 0x07 returns the selected device number.
- R8: Indices 0x30–0x3F reach a 16-byte bank that is private to the selected logical device. Each of the four banks holds its own contents.
- R9: Indices 0x20–0x2F reach global registers whose contents do not depend on the device selection.
- R10: Indices other than 0x07, 0x20–0x2F and 0x30–0x3F read 0x00, and writes to them are dropped.
- R11: The index, the device selection and all register contents survive a lock/unlock cycle.
- R12: After reset the port is closed, the index is 0x00, device 0 is selected and every register is 0x00. The exception is bit 6 of 0x26, which takes strap_i.
- R13: rdata_o is 0x00 unless a read strobe targets the currently decoded base or base+1 address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Reset value of the base-select bit |
| addr_i | input | 16 | I/O address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational on the read strobe |

## Verification
The assertions assume that each write strobe lasts exactly one clock cycle and carries one bus write. They also assume that read and write strobes never occur in the same cycle. The bench drives every access through a single write task and a single read task, each of which holds its strobe for one cycle and releases it before the next access begins. The same tasks keep reads free of side effects, so a read can be placed between any two writes without disturbing unlock progress.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_BYTE  = 8'h87;
  localparam logic [7:0] EXIT_BYTE = 8'hAA;
  localparam logic [7:0] LOCK_READ = 8'hFF;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       port_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic [7:0] idx_o
);
  lock_state_e state_q, state_d;
  logic [7:0]  idx_q;

  always_comb begin
    state_d = state_q;
    if (port_wr_i) begin
      unique case (state_q)
        LK_IDLE: state_d = (wdata_i == KEY_BYTE) ? LK_HALF : LK_IDLE;
        LK_HALF: state_d = (wdata_i == KEY_BYTE) ? LK_OPEN : LK_IDLE;
        LK_OPEN: state_d = (wdata_i == EXIT_BYTE) ? LK_IDLE : LK_OPEN;
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_IDLE;
      idx_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      // index loads only from writes that stay inside the open state
      if (port_wr_i && state_q == LK_OPEN && wdata_i != EXIT_BYTE)
        idx_q <= wdata_i;
    end
  end

  assign open_o = (state_q == LK_OPEN);
  assign idx_o  = idx_q;

  p_open_after_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> ($past(state_q) == LK_HALF) && $past(port_wr_i)
                      && ($past(wdata_i) == KEY_BYTE));

  p_exit_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && port_wr_i && wdata_i == EXIT_BYTE) |=> (!open_o && $stable(idx_o)));

  p_broken_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && port_wr_i && wdata_i != KEY_BYTE) |=> (state_q == LK_IDLE));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int         NUM_LDEV   = 4,
  parameter int         BANK_DEPTH = 16,
  parameter int         GLB_DEPTH  = 16,
  parameter logic [7:0] LDN_IDX    = 8'h07,
  parameter logic [7:0] GLB_START  = 8'h20,
  parameter logic [7:0] BANK_START = 8'h30,
  parameter logic [7:0] SEL_IDX    = 8'h26,
  parameter int         SEL_BIT    = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       wr_en_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       base_sel_o
);
  localparam int         LDN_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam int         GLB_AW   = $clog2(GLB_DEPTH);
  localparam int         BANK_AW  = $clog2(BANK_DEPTH);
  localparam int         BANK_TOT = NUM_LDEV * BANK_DEPTH;
  localparam logic [8:0] GLB_END  = 9'(int'(GLB_START) + GLB_DEPTH);
  localparam logic [8:0] BANK_END = 9'(int'(BANK_START) + BANK_DEPTH);
  localparam int         SEL_OFF  = int'(SEL_IDX) - int'(GLB_START);

  logic [LDN_W-1:0]               ldn_q;
  logic [GLB_DEPTH-1:0][7:0]      glb_q;
  logic [BANK_TOT-1:0][7:0]       bank_q;

  logic                           hit_ldn, hit_glb, hit_bank;
  logic [GLB_AW-1:0]              glb_off;
  logic [BANK_AW-1:0]             bank_off;
  logic [LDN_W+BANK_AW-1:0]       bank_addr;

  assign hit_ldn   = (idx_i == LDN_IDX);
  assign hit_glb   = (idx_i >= GLB_START) && ({1'b0, idx_i} < GLB_END);
  assign hit_bank  = (idx_i >= BANK_START) && ({1'b0, idx_i} < BANK_END);
  assign glb_off   = GLB_AW'(idx_i - GLB_START);
  assign bank_off  = BANK_AW'(idx_i - BANK_START);
  assign bank_addr = {ldn_q, bank_off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q                  <= '0;
      glb_q                  <= '0;
      glb_q[SEL_OFF][SEL_BIT] <= strap_i;
      bank_q                 <= '0;
    end else if (wr_en_i) begin
      if (hit_ldn)       ldn_q              <= LDN_W'(wdata_i);
      else if (hit_glb)  glb_q[glb_off]     <= wdata_i;
      else if (hit_bank) bank_q[bank_addr]  <= wdata_i;
    end
  end

  always_comb begin
    if (hit_ldn)       rdata_o = 8'(ldn_q);
    else if (hit_glb)  rdata_o = glb_q[glb_off];
    else if (hit_bank) rdata_o = bank_q[bank_addr];
    else               rdata_o = 8'h00;
  end

  assign base_sel_o = glb_q[SEL_OFF][SEL_BIT];

  p_ldn_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && hit_ldn) |=> $stable(ldn_q));

  p_no_write_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(glb_q) && $stable(bank_q) && $stable(ldn_q)));

  p_unimpl_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_ldn && !hit_glb && !hit_bank)
      |=> ($stable(glb_q) && $stable(bank_q) && $stable(ldn_q)));

  p_glb_ldn_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_ldn) |=> $stable(glb_q));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_LO    = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI    = 16'h004E,
  parameter int                NUM_LDEV   = 4,
  parameter int                BANK_DEPTH = 16,
  parameter int                GLB_DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o
);
  logic              base_sel, open, hit_idx, hit_dat;
  logic [ADDR_W-1:0] base_addr;
  logic [7:0]        idx, rf_rdata;

  assign base_addr = base_sel ? BASE_HI : BASE_LO;
  assign hit_idx   = (addr_i == base_addr);
  assign hit_dat   = (addr_i == base_addr + ADDR_W'(1));

  cfg_lock_fsm u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_wr_i (wr_i && hit_idx),
    .wdata_i   (wdata_i),
    .open_o    (open),
    .idx_o     (idx)
  );

  cfg_regfile #(
    .NUM_LDEV   (NUM_LDEV),
    .BANK_DEPTH (BANK_DEPTH),
    .GLB_DEPTH  (GLB_DEPTH)
  ) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .wr_en_i    (wr_i && hit_dat && open),
    .idx_i      (idx),
    .wdata_i    (wdata_i),
    .rdata_o    (rf_rdata),
    .base_sel_o (base_sel)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i && hit_idx)      rdata_o = open ? idx      : LOCK_READ;
    else if (rd_i && hit_dat) rdata_o = open ? rf_rdata : LOCK_READ;
  end

  p_base_move_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_sel != $past(base_sel)) |-> ($past(wr_i) && $past(open)));

  p_quiet_bus_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));
endmodule

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  cfg_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #3 d = rdata;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_wr(input logic [15:0] b, input logic [7:0] i, input logic [7:0] d);
    bus_wr(b, i);
    bus_wr(b + 16'h1, d);
  endtask

  task automatic reg_rd(input logic [15:0] b, input logic [7:0] i, output logic [7:0] d);
    bus_wr(b, i);
    bus_rd(b + 16'h1, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(16'h2F, v); chk("R12 locked data read", v, 8'hFF);
    bus_rd(16'h2E, v); chk("R4 locked index read", v, 8'hFF);
    bus_wr(16'h2E, 8'h87); bus_wr(16'h2E, 8'h87);
    bus_rd(16'h2E, v); chk("R12 index reset", v, 8'h00);
    bus_rd(16'h2F, v); chk("R10 index 00 unimplemented", v, 8'h00);
    reg_rd(16'h2E, 8'h07, v); chk("R12 device reset", v, 8'h00);
    reg_rd(16'h2E, 8'h26, v); chk("R12 select reg strap 0", v, 8'h00);
    bus_rd(16'h30, v); chk("R13 undecoded read", v, 8'h00);
  endtask

  task automatic t_broken();
    logic [7:0] v;
    bus_wr(16'h2E, 8'hAA);
    bus_wr(16'h2E, 8'h87); bus_wr(16'h2E, 8'h12); bus_wr(16'h2E, 8'h87);
    bus_rd(16'h2F, v); chk("R2 broken pair stays locked", v, 8'hFF);
    bus_wr(16'h2E, 8'h87);
    bus_rd(16'h2E, v); chk("R1 pair opens, index kept", v, 8'h26);
  endtask

  task automatic t_exit_locked_write();
    logic [7:0] v;
    reg_wr(16'h2E, 8'h20, 8'h3C);
    bus_wr(16'h2E, 8'hAA);
    bus_rd(16'h2F, v); chk("R3 exit locks", v, 8'hFF);
    bus_wr(16'h2F, 8'h55);
    bus_wr(16'h2E, 8'h87); bus_wr(16'h2E, 8'h87);
    bus_rd(16'h2E, v); chk("R3 reopen, index", v, 8'h20);
    bus_rd(16'h2F, v); chk("R5 locked write ignored", v, 8'h3C);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    for (int d = 0; d < 4; d++) begin
      reg_wr(16'h2E, 8'h07, 8'(d));
      reg_wr(16'h2E, 8'h30, 8'(8'h10 * d + 5));
      reg_wr(16'h2E, 8'h3F, 8'(8'hC0 + d));
    end
    reg_rd(16'h2E, 8'h07, v); chk("R7 device readback", v, 8'h03);
    for (int d = 0; d < 4; d++) begin
      reg_wr(16'h2E, 8'h07, 8'(d));
      reg_rd(16'h2E, 8'h30, v); chk("R8 bank first reg", v, 8'(8'h10 * d + 5));
      reg_rd(16'h2E, 8'h3F, v); chk("R8 bank last reg", v, 8'(8'hC0 + d));
    end
  endtask

  task automatic t_global();
    logic [7:0] v;
    reg_wr(16'h2E, 8'h07, 8'h00);
    reg_wr(16'h2E, 8'h21, 8'hA5);
    reg_wr(16'h2E, 8'h07, 8'h02);
    reg_rd(16'h2E, 8'h21, v); chk("R9 global across devices", v, 8'hA5);
    reg_wr(16'h2E, 8'h2F, 8'h5A);
    reg_wr(16'h2E, 8'h07, 8'h01);
    reg_rd(16'h2E, 8'h2F, v); chk("R9 global last reg", v, 8'h5A);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    reg_wr(16'h2E, 8'h05, 8'h77);
    bus_rd(16'h2F, v); chk("R10 low unimplemented", v, 8'h00);
    reg_wr(16'h2E, 8'h40, 8'h77);
    bus_rd(16'h2F, v); chk("R10 high unimplemented", v, 8'h00);
    reg_wr(16'h2E, 8'h1F, 8'h77);
    bus_rd(16'h2F, v); chk("R10 below global", v, 8'h00);
    reg_rd(16'h2E, 8'h21, v); chk("R10 neighbours intact", v, 8'hA5);
  endtask

  task automatic t_survive();
    logic [7:0] v;
    reg_wr(16'h2E, 8'h07, 8'h01);
    reg_wr(16'h2E, 8'h31, 8'h9E);
    bus_wr(16'h2E, 8'hAA);
    bus_wr(16'h2E, 8'h87); bus_wr(16'h2E, 8'h87);
    bus_rd(16'h2E, v); chk("R11 index survives", v, 8'h31);
    bus_rd(16'h2F, v); chk("R11 bank value survives", v, 8'h9E);
    reg_rd(16'h2E, 8'h07, v); chk("R11 device survives", v, 8'h01);
  endtask

  task automatic t_base_sel();
    logic [7:0] v;
    reg_wr(16'h2E, 8'h26, 8'h40);
    bus_rd(16'h2F, v); chk("R6 old data port gone", v, 8'h00);
    bus_rd(16'h4E, v); chk("R6 new index port", v, 8'h26);
    bus_rd(16'h4F, v); chk("R6 select reg via new port", v, 8'h40);
    bus_wr(16'h4E, 8'hAA);
    bus_wr(16'h2E, 8'h87); bus_wr(16'h2E, 8'h87);
    bus_rd(16'h4F, v); chk("R6 old base cannot unlock", v, 8'hFF);
    bus_wr(16'h4E, 8'h87); bus_wr(16'h4E, 8'h87);
    reg_wr(16'h4E, 8'h26, 8'h00);
    bus_rd(16'h2E, v); chk("R6 back to low base", v, 8'h26);
  endtask

  task automatic t_strap();
    logic [7:0] v;
    do_reset(1'b1);
    bus_wr(16'h4E, 8'h87); bus_wr(16'h4E, 8'h87);
    reg_rd(16'h4E, 8'h26, v); chk("R6 strap sets select bit", v, 8'h40);
    reg_rd(16'h4E, 8'h21, v); chk("R12 global cleared", v, 8'h00);
    bus_rd(16'h2E, v); chk("R13 low base undecoded", v, 8'h00);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    t_broken();
    t_exit_locked_write();
    t_banks();
    t_global();
    t_unimpl();
    t_survive();
    t_base_sel();
    t_strap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule